// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two independent direction predictors and a learned selector between them. The first follows the shared history of recent branch outcomes: a global history register directly indexes a table of 2-bit counters. The second follows each branch's own recent behaviour: a per-PC table of local histories selects an entry in a table of 3-bit counters. A third table of 2-bit counters, indexed by the global history, records which of the two has been more reliable and picks the final answer.

A lookup is purely combinational. The fetch stage presents a PC and gets back the prediction together with a snapshot: the global history used, the local table index, the local history read, and both component predictions. The fetch stage keeps this snapshot with the branch. When the branch resolves, the snapshot comes back on the resolve port with the actual outcome. All training uses the returned indices, so branches still in flight at lookup time do not corrupt each other's updates. History is updated at resolve time only. At the default sizes the state comes to roughly 29K bits.

Top module: `bpd_tournament`

## Requirements
- R1: After reset, every history (global register and all local entries) is zero. The 2-bit global and chooser counters are 1 and the 3-bit local counters are 3. Every lookup therefore reports not-taken for both components and for the final prediction.
- R2: The global history is GHIST_W bits wide. Bit 0 holds the most recent resolved outcome and bit i the outcome i+1 resolves back (1 = taken). Each resolve shifts the outcome in at bit 0. `snap_ghist` shows the register's current value.
- R3: The global table holds 2^GHIST_W counters of GCTR_W bits, read at the current global history. A counter predicts taken when its MSB is 1. On resolve, the entry at `rs_ghist` counts up on taken and down on not-taken, saturating at 0 and at its maximum.
- R4: The local history table has 2^LIDX_W entries of LHIST_W bits, indexed by PC bits [LIDX_W+1:2] (`snap_lidx`). On resolve, the entry at `rs_lidx` shifts the outcome in at bit 0.
- R5: The local table holds 2^LHIST_W counters of LCTR_W bits, indexed by the local history read at lookup. It has the same MSB rule and saturating update as the global table, applied at `rs_lhist`.
- R6: The chooser counter at the current global history selects the final prediction: global when its MSB is 1, local otherwise.
- R7: The chooser entry at `rs_ghist` changes only when `rs_gpred` and `rs_lpred` differ. It counts up if the global side matched the outcome and down otherwise, saturating.
- R8: Updates use only the indices returned on the resolve port, even when other branches have resolved since the lookup. Resolves are applied in the order presented.
- R9: A lookup alters no state. With `rs_valid` low, all state holds, and a repeated lookup returns an identical snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch PC for lookup |
| pred_taken | output | 1 | Final taken prediction |
| snap_ghist | output | GHIST_W | Global history used by the lookup |
| snap_lidx | output | LIDX_W | Local history table index |
| snap_lhist | output | LHIST_W | Local history read by the lookup |
| snap_gpred | output | 1 | Global component prediction |
| snap_lpred | output | 1 | Local component prediction |
| rs_valid | input | 1 | Resolve update strobe |
| rs_taken | input | 1 | Actual branch outcome |
| rs_ghist | input | GHIST_W | Returned global history snapshot |
| rs_lidx | input | LIDX_W | Returned local table index |
| rs_lhist | input | LHIST_W | Returned local history snapshot |
| rs_gpred | input | 1 | Returned global component prediction |
| rs_lpred | input | 1 | Returned local component prediction |

## Verification
A wrong history bit appears at once in `snap_ghist` or `snap_lhist` on the next lookup after the faulty resolve. A wrong counter step is hidden until that entry crosses its MSB threshold, which for a 3-bit local counter can take up to four further resolves. A chooser fault surfaces in `pred_taken` only where the two component predictions disagree. The bench therefore runs a small configuration long enough that every table entry crosses its threshold both ways. It compares every snapshot field against an arithmetic model after each lookup, with resolves reordered so that stale indices are exercised.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  // Saturating step of an unsigned counter of width w (w <= 8).
  function automatic logic [7:0] sat_step(input logic [7:0] cur, input logic up, input int w);
    logic [7:0] top;
    top = 8'((1 << w) - 1);
    if (up) return (cur == top) ? cur : cur + 8'd1;
    else    return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction

  // Weakly-not-taken starting value for a counter of width w.
  function automatic int weak_nt(input int w);
    return (1 << (w - 1)) - 1;
  endfunction

endpackage

// File: rtl/bpd_ctr_table.sv
module bpd_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] INIT = CTR_W'(bpd_pkg::weak_nt(CTR_W));

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] wr_cur;
  logic [CTR_W-1:0] wr_nxt;

  assign rd_ctr = mem[rd_idx];
  assign wr_cur = mem[wr_idx];

  always_comb begin
    wr_nxt = CTR_W'(bpd_pkg::sat_step(8'(wr_cur), wr_up, CTR_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_nxt;
    end
  end
endmodule

// File: rtl/bpd_hist_table.sv
module bpd_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [HIST_W-1:0] wr_cur;

  assign rd_hist = mem[rd_idx];
  assign wr_cur  = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {wr_cur[HIST_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/bpd_tournament.sv
module bpd_tournament #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GCTR_W  = 2,
  parameter int LCTR_W  = 3,
  parameter int CCTR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    lk_pc,
  output logic               pred_taken,
  output logic [GHIST_W-1:0] snap_ghist,
  output logic [LIDX_W-1:0]  snap_lidx,
  output logic [LHIST_W-1:0] snap_lhist,
  output logic               snap_gpred,
  output logic               snap_lpred,
  input  logic               rs_valid,
  input  logic               rs_taken,
  input  logic [GHIST_W-1:0] rs_ghist,
  input  logic [LIDX_W-1:0]  rs_lidx,
  input  logic [LHIST_W-1:0] rs_lhist,
  input  logic               rs_gpred,
  input  logic               rs_lpred
);
  localparam int PC_LSB = 2;
  localparam int PC_MSB = LIDX_W + PC_LSB - 1;

  // Named internal events, used by the bound checker.
  logic [GHIST_W-1:0] ghr;
  logic [GCTR_W-1:0]  gctr;
  logic [LCTR_W-1:0]  lctr;
  logic [CCTR_W-1:0]  cctr;
  logic               use_global;
  logic               ch_upd;
  logic               ch_up;
  logic               pc_unused;

  assign pc_unused  = ^{lk_pc[PC_W-1:PC_MSB+1], lk_pc[PC_LSB-1:0]};
  assign snap_lidx  = lk_pc[PC_MSB:PC_LSB];
  assign snap_ghist = ghr;
  assign snap_gpred = gctr[GCTR_W-1];
  assign snap_lpred = lctr[LCTR_W-1];
  assign use_global = cctr[CCTR_W-1];
  assign pred_taken = use_global ? snap_gpred : snap_lpred;

  assign ch_upd = rs_valid && (rs_gpred != rs_lpred);
  assign ch_up  = (rs_gpred == rs_taken);

  always_ff @(posedge clk) begin
    if (!rst_n)        ghr <= '0;
    else if (rs_valid) ghr <= {ghr[GHIST_W-2:0], rs_taken};
  end

  bpd_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) gpat_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghr), .rd_ctr(gctr),
    .wr_en(rs_valid), .wr_idx(rs_ghist), .wr_up(rs_taken));

  bpd_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) lhist_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(snap_lidx), .rd_hist(snap_lhist),
    .wr_en(rs_valid), .wr_idx(rs_lidx), .wr_bit(rs_taken));

  bpd_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) lpat_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(snap_lhist), .rd_ctr(lctr),
    .wr_en(rs_valid), .wr_idx(rs_lhist), .wr_up(rs_taken));

  bpd_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CCTR_W)) choose_i (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghr), .rd_ctr(cctr),
    .wr_en(ch_upd), .wr_idx(rs_ghist), .wr_up(ch_up));
endmodule

// File: rtl/bpd_tournament_chk.sv
module bpd_tournament_chk #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PC_W-1:0]    lk_pc,
  input logic [GHIST_W-1:0] ghr,
  input logic               rs_valid,
  input logic               rs_taken,
  input logic               rs_gpred,
  input logic               rs_lpred,
  input logic               ch_upd,
  input logic               pred_taken,
  input logic               snap_gpred,
  input logic               snap_lpred
);
  // R1
  ghr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ghr == '0);

  // R2
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> ghr == {$past(ghr[GHIST_W-2:0]), $past(rs_taken)});

  // R9
  ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(ghr));

  // R9
  lookup_pure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> (!$stable(lk_pc) || $stable(pred_taken)));

  // R6
  agree_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_gpred == snap_lpred) |-> pred_taken == snap_gpred);

  // R7
  chooser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_gpred == rs_lpred) |-> !ch_upd);
endmodule

bind bpd_tournament bpd_tournament_chk #(.PC_W(PC_W), .GHIST_W(GHIST_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .ghr(ghr), .rs_valid(rs_valid),
  .rs_taken(rs_taken), .rs_gpred(rs_gpred), .rs_lpred(rs_lpred), .ch_upd(ch_upd),
  .pred_taken(pred_taken), .snap_gpred(snap_gpred), .snap_lpred(snap_lpred));

// File: tb/bpd_tournament_tb_top.sv
module bpd_tournament_tb_top;
  localparam int PC_W = 8, GH_W = 4, LI_W = 2, LH_W = 3;
  localparam int G_MAX = 3, L_MAX = 7, C_MAX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic pred_taken, snap_gpred, snap_lpred;
  logic [GH_W-1:0] snap_ghist;
  logic [LI_W-1:0] snap_lidx;
  logic [LH_W-1:0] snap_lhist;
  logic rs_valid = 1'b0, rs_taken = 1'b0, rs_gpred = 1'b0, rs_lpred = 1'b0;
  logic [GH_W-1:0] rs_ghist = '0;
  logic [LI_W-1:0] rs_lidx = '0;
  logic [LH_W-1:0] rs_lhist = '0;

  always #2 clk = ~clk;

  bpd_tournament #(.PC_W(PC_W), .GHIST_W(GH_W), .LIDX_W(LI_W), .LHIST_W(LH_W),
                   .GCTR_W(2), .LCTR_W(3), .CCTR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .snap_ghist(snap_ghist), .snap_lidx(snap_lidx), .snap_lhist(snap_lhist),
    .snap_gpred(snap_gpred), .snap_lpred(snap_lpred), .rs_valid(rs_valid),
    .rs_taken(rs_taken), .rs_ghist(rs_ghist), .rs_lidx(rs_lidx),
    .rs_lhist(rs_lhist), .rs_gpred(rs_gpred), .rs_lpred(rs_lpred));

  int errs = 0, checks = 0;
  bit done = 0;
  int gpt[16], lpt[8], cht[16], lht[4];
  int ghr_m;
  int lfsr = 16'hACE1;
  int alt_bit = 0, last_out = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bump(input int c, input int up, input int mx);
    if (up != 0) return (c < mx) ? c + 1 : c;
    return (c > 0) ? c - 1 : c;
  endfunction

  task automatic model_reset();
    foreach (gpt[i]) gpt[i] = 1;
    foreach (lpt[i]) lpt[i] = 3;
    foreach (cht[i]) cht[i] = 1;
    foreach (lht[i]) lht[i] = 0;
    ghr_m = 0;
  endtask

  task automatic lookup(input int pc, output int gh, output int li, output int lh,
                        output int gp, output int lp);
    int pr;
    @(negedge clk);
    lk_pc = PC_W'(pc);
    #1;
    gh = ghr_m;
    li = (pc / 4) % 4;
    lh = lht[li];
    gp = (gpt[gh] >= 2) ? 1 : 0;
    lp = (lpt[lh] >= 4) ? 1 : 0;
    pr = (cht[gh] >= 2) ? gp : lp;
    chk("R2 ghist", int'(snap_ghist), gh);
    chk("R4 lidx", int'(snap_lidx), li);
    chk("R4 lhist", int'(snap_lhist), lh);
    chk("R3 gpred", int'(snap_gpred), gp);
    chk("R5 lpred", int'(snap_lpred), lp);
    chk("R6 R7 R8 pred", int'(pred_taken), pr);
  endtask

  task automatic resolve(input int t, input int gh, input int li, input int lh,
                         input int gp, input int lp);
    @(negedge clk);
    rs_taken = t[0]; rs_ghist = GH_W'(gh); rs_lidx = LI_W'(li);
    rs_lhist = LH_W'(lh); rs_gpred = gp[0]; rs_lpred = lp[0];
    rs_valid = 1'b1;
    @(posedge clk);
    #1 rs_valid = 1'b0;
    gpt[gh] = bump(gpt[gh], t, G_MAX);
    lpt[lh] = bump(lpt[lh], t, L_MAX);
    if (gp != lp) cht[gh] = bump(cht[gh], (gp == t) ? 1 : 0, C_MAX);
    lht[li] = ((lht[li] * 2) + t) % 8;
    ghr_m = ((ghr_m * 2) + t) % 16;
  endtask

  function automatic int step_lfsr(input int v);
    int fb;
    fb = ((v >> 0) ^ (v >> 2) ^ (v >> 3) ^ (v >> 5)) & 1;
    return ((v >> 1) | (fb << 15)) & 16'hFFFF;
  endfunction

  function automatic int outcome(input int pc, input int rnd);
    case ((pc / 4) % 4)
      0: return 1;
      1: return alt_bit;
      2: return last_out;
      default: return rnd & 1;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int gh, li, lh, gp, lp, gh2, li2, lh2, gp2, lp2, ta, tb, pa, pb;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state seen at every local index
    for (int p = 0; p < 16; p += 4) begin
      lookup(p, gh, li, lh, gp, lp);
      chk("R1 reset pred", int'(pred_taken), 0);
      chk("R1 reset ghist", int'(snap_ghist), 0);
    end

    // Main sweep: two branches in flight, resolves reordered (R8)
    for (int s = 0; s < 4000; s++) begin
      lfsr = step_lfsr(lfsr);
      pa = lfsr & 8'hFF;
      lfsr = step_lfsr(lfsr);
      pb = lfsr & 8'hFF;
      lookup(pa, gh, li, lh, gp, lp);
      lookup(pb, gh2, li2, lh2, gp2, lp2);
      ta = outcome(pa, lfsr >> 3);
      tb = outcome(pb, lfsr >> 7);
      if ((s % 2) == 0) begin
        resolve(ta, gh, li, lh, gp, lp);
        resolve(tb, gh2, li2, lh2, gp2, lp2);
      end else begin
        resolve(tb, gh2, li2, lh2, gp2, lp2);
        resolve(ta, gh, li, lh, gp, lp);
      end
      last_out = ta;
      alt_bit = 1 - alt_bit;
    end

    // R9: lookups alone change nothing
    lookup(20, gh, li, lh, gp, lp);
    for (int p = 0; p < 64; p++) lookup(p * 3, gh2, li2, lh2, gp2, lp2);
    lookup(20, gh2, li2, lh2, gp2, lp2);
    chk("R9 repeat ghist", gh2, gh);
    chk("R9 repeat lhist", lh2, lh);
    chk("R9 repeat pred", int'(pred_taken), (cht[gh] >= 2) ? gp : lp);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule